// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Victim Buffer

This block serves 32-bit instruction fetches from a direct-mapped line array. A small, fully associative victim buffer sits behind it and holds lines that were recently pushed out of the array. A fetch first looks in the main array. If that misses, every victim entry is compared. A victim match exchanges the two lines, so two hot lines that share an index can both stay on chip. If both structures miss, the line is fetched over a ready/valid request channel followed by an in-order word stream. Before that fill, a valid resident line is pushed into the victim slot chosen by a round-robin pointer.

Only one request is in flight at a time. A global flush clears every valid bit in both structures and sets the insertion pointer back to zero. Line size, line count and victim depth are parameters. The defaults are 16-byte lines, 16 lines and 16 victim entries, which keep elaboration small. The same structure scales to 256-byte lines and 256 lines.

Top module: `icache_vb`

## Requirements
- R1: A request address splits from the least significant bit upward as follows. Bits [1:0] are ignored. Bits [OFFSET_W-1:2] select the word in the line, bits [OFFSET_W+INDEX_W-1:OFFSET_W] select the line, and the remaining upper bits form the tag. A fill request carries the request address with bits [OFFSET_W-1:0] forced to zero.
- R2: On a main-array hit, `rsp_valid_o` is high for one cycle, in the cycle after acceptance, with the addressed word. The victim buffer is left unchanged.
- R3: On a main miss that matches a victim entry whose key is {tag, index}, the response comes two cycles after acceptance. The two lines swap. Afterwards the requested line hits in the main array, and the displaced line is held in that victim entry under its own {tag, index} key.
- R4: On a miss in both structures, `fill_req_valid_o` rises in the cycle after acceptance and holds, with a stable address, until `fill_req_ready_i`. The line then arrives as LINE_WORDS words in ascending order, each marked by `fill_data_valid_i`. The response comes in the cycle after the last word.
- R5: On a miss in both structures, a valid resident line is written into the victim slot at the round-robin pointer, and the pointer advances modulo VICTIM_N. The oldest eviction is therefore overwritten first.
- R6: An invalid resident line is not written into the victim buffer on a miss, and the pointer does not move.
- R7: `flush_i`, taken while idle, invalidates every main line and every victim entry and resets the pointer to zero. Every later fetch then misses.
- R8: `req_ready_o` is low while a swap or fill is in progress, and also while `flush_i` is high. A request offered at such a time is not taken.
- R9: A filled line is written valid with the new tag and with all LINE_WORDS words, so later fetches of any word in it hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Global invalidate, taken while idle |
| req_valid_i | input | 1 | Fetch request valid |
| req_ready_o | output | 1 | Fetch request can be taken |
| req_addr_i | input | 32 | Fetch byte address |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_data_o | output | 32 | Fetched instruction word |
| fill_req_valid_o | output | 1 | Line fill request valid |
| fill_req_ready_i | input | 1 | Line fill request accepted |
| fill_req_addr_o | output | 32 | Line-aligned fill address |
| fill_data_valid_i | input | 1 | Fill word strobe |
| fill_data_i | input | 32 | Fill word, ascending order |

## Verification
A main hit answers one cycle after the accepting edge and a victim swap answers after two. A fill answers one cycle after the last fill word, so its latency depends on when the bench grants the request and on any gaps it leaves between words. The bench serves fills with a fixed pattern: it grants one cycle late and leaves one idle cycle inside the word stream. This fixes a miss latency of LINE_WORDS+4 cycles. On every falling edge after a request, the bench compares `rsp_valid_o`, `req_ready_o` and, in the due cycle, `rsp_data_o` against what its behavioural tag/victim model predicts for that cycle.

// File: rtl/icv_pkg.sv
package icv_pkg;
  localparam int DATA_W = 32;
  typedef enum logic [1:0] {ST_IDLE, ST_SWAP, ST_FREQ, ST_FDATA} icv_state_e;
endpackage

// File: rtl/icv_main_array.sv
module icv_main_array #(
  parameter int INDEX_W = 4,
  parameter int TAG_W   = 24,
  parameter int LW      = 4,
  parameter int DW      = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   inv_i,
  input  logic [INDEX_W-1:0]     idx_i,
  output logic                   valid_o,
  output logic [TAG_W-1:0]       tag_o,
  output logic [LW-1:0][DW-1:0]  line_o,
  input  logic                   meta_we_i,
  input  logic                   meta_valid_i,
  input  logic [TAG_W-1:0]       meta_tag_i,
  input  logic                   line_we_i,
  input  logic [LW-1:0][DW-1:0]  line_i,
  input  logic                   word_we_i,
  input  logic [$clog2(LW)-1:0]  word_off_i,
  input  logic [DW-1:0]          word_i
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0]      vld_q;
  logic [TAG_W-1:0]      tag_q [LINES];
  logic [LW-1:0][DW-1:0] dat_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        vld_q <= '0;
    else if (inv_i)     vld_q <= '0;
    else if (meta_we_i) vld_q[idx_i] <= meta_valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (meta_we_i) tag_q[idx_i] <= meta_tag_i;
    if (line_we_i)      dat_q[idx_i] <= line_i;
    else if (word_we_i) dat_q[idx_i][word_off_i] <= word_i;
  end

  assign valid_o = vld_q[idx_i];
  assign tag_o   = tag_q[idx_i];
  assign line_o  = dat_q[idx_i];

  // swap writes a whole line, fill writes words: never both at once
  p_line_word_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(line_we_i && word_we_i));
  p_inv_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i |=> !valid_o);
endmodule

// File: rtl/icv_victim_buf.sv
module icv_victim_buf #(
  parameter int N     = 16,
  parameter int KEY_W = 28,
  parameter int LW    = 4,
  parameter int DW    = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  inv_i,
  input  logic [KEY_W-1:0]      key_i,
  output logic                  hit_o,
  output logic [LW-1:0][DW-1:0] hit_line_o,
  input  logic                  ins_i,
  input  logic [KEY_W-1:0]      ins_key_i,
  input  logic [LW-1:0][DW-1:0] ins_line_i,
  input  logic                  sw_i,
  input  logic                  sw_valid_i,
  input  logic [KEY_W-1:0]      sw_key_i,
  input  logic [LW-1:0][DW-1:0] sw_line_i
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]          vld_q;
  logic [KEY_W-1:0]      key_q [N];
  logic [LW-1:0][DW-1:0] line_q [N];
  logic [PW-1:0]         ptr_q;
  logic [N-1:0]          match;
  logic [PW-1:0]         sel;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (key_q[g] == key_i);
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < N; i++)
      if (match[i]) sel = PW'(i);
  end

  assign hit_o      = |match;
  assign hit_line_o = line_q[sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (inv_i) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (ins_i) begin
      vld_q[ptr_q] <= 1'b1;
      ptr_q <= (ptr_q == PW'(N - 1)) ? '0 : ptr_q + 1'b1;
    end else if (sw_i) begin
      vld_q[sel] <= sw_valid_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (ins_i) begin
      key_q[ptr_q]  <= ins_key_i;
      line_q[ptr_q] <= ins_line_i;
    end else if (sw_i) begin
      key_q[sel]  <= sw_key_i;
      line_q[sel] <= sw_line_i;
    end
  end

  p_ptr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_i && !inv_i) |=> (ptr_q == (($past(ptr_q) == PW'(N - 1)) ? '0 : $past(ptr_q) + 1'b1)));
  p_ptr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ins_i && !inv_i) |=> $stable(ptr_q));
  p_ptr_flush_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i |=> (ptr_q == '0) && (vld_q == '0));
  p_key_unique_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
endmodule

// File: rtl/icache_vb.sv
module icache_vb
  import icv_pkg::*;
#(
  parameter int OFFSET_W = 4,
  parameter int INDEX_W  = 4,
  parameter int VICTIM_N = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        flush_i,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [31:0] req_addr_i,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_data_o,
  output logic        fill_req_valid_o,
  input  logic        fill_req_ready_i,
  output logic [31:0] fill_req_addr_o,
  input  logic        fill_data_valid_i,
  input  logic [31:0] fill_data_i
);
  localparam int WOFF_W = OFFSET_W - 2;
  localparam int LW     = 1 << WOFF_W;
  localparam int TAG_W  = 32 - OFFSET_W - INDEX_W;
  localparam int KEY_W  = TAG_W + INDEX_W;

  icv_state_e                 state_q;
  logic [31:0]                addr_q;
  logic [WOFF_W-1:0]          cnt_q;
  logic [31:0]                cur_addr;
  logic [INDEX_W-1:0]         cur_idx;
  logic [TAG_W-1:0]           cur_tag;
  logic [WOFF_W-1:0]          cur_woff;
  logic                       idle, acc, main_hit, fill_last, word_we, meta_we;
  logic                       m_valid, v_hit, v_ins;
  logic [TAG_W-1:0]           m_tag;
  logic [LW-1:0][DATA_W-1:0]  m_line, v_line;

  assign idle     = (state_q == ST_IDLE);
  assign cur_addr = idle ? req_addr_i : addr_q;
  assign cur_idx  = cur_addr[OFFSET_W +: INDEX_W];
  assign cur_tag  = cur_addr[31 -: TAG_W];
  assign cur_woff = cur_addr[2 +: WOFF_W];

  assign req_ready_o = idle && !flush_i;
  assign acc         = req_valid_i && req_ready_o;
  assign main_hit    = m_valid && (m_tag == cur_tag);
  assign v_ins       = acc && !main_hit && !v_hit && m_valid;
  assign word_we     = (state_q == ST_FDATA) && fill_data_valid_i;
  assign fill_last   = word_we && (cnt_q == WOFF_W'(LW - 1));
  assign meta_we     = (acc && !main_hit && !v_hit) || (state_q == ST_SWAP) || fill_last;

  assign fill_req_valid_o = (state_q == ST_FREQ);
  assign fill_req_addr_o  = {addr_q[31:OFFSET_W], {OFFSET_W{1'b0}}};

  icv_main_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .LW(LW), .DW(DATA_W)) u_main (
    .clk_i, .rst_ni,
    .inv_i        (idle && flush_i),
    .idx_i        (cur_idx),
    .valid_o      (m_valid),
    .tag_o        (m_tag),
    .line_o       (m_line),
    .meta_we_i    (meta_we),
    .meta_valid_i (!idle),          // cleared while a fill is pending, set by swap/fill
    .meta_tag_i   (cur_tag),
    .line_we_i    (state_q == ST_SWAP),
    .line_i       (v_line),
    .word_we_i    (word_we),
    .word_off_i   (cnt_q),
    .word_i       (fill_data_i)
  );

  icv_victim_buf #(.N(VICTIM_N), .KEY_W(KEY_W), .LW(LW), .DW(DATA_W)) u_vict (
    .clk_i, .rst_ni,
    .inv_i      (idle && flush_i),
    .key_i      ({cur_tag, cur_idx}),
    .hit_o      (v_hit),
    .hit_line_o (v_line),
    .ins_i      (v_ins),
    .ins_key_i  ({m_tag, cur_idx}),
    .ins_line_i (m_line),
    .sw_i       (state_q == ST_SWAP),
    .sw_valid_i (m_valid),
    .sw_key_i   ({m_tag, cur_idx}),
    .sw_line_i  (m_line)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      cnt_q       <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (acc) begin
          addr_q <= req_addr_i;
          if (main_hit) begin
            rsp_valid_o <= 1'b1;
            rsp_data_o  <= m_line[cur_woff];
          end else if (v_hit) state_q <= ST_SWAP;
          else                state_q <= ST_FREQ;
        end
        ST_SWAP: begin
          rsp_valid_o <= 1'b1;
          rsp_data_o  <= v_line[cur_woff];
          state_q     <= ST_IDLE;
        end
        ST_FREQ: if (fill_req_ready_i) begin
          cnt_q   <= '0;
          state_q <= ST_FDATA;
        end
        ST_FDATA: if (fill_data_valid_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (fill_last) begin
            rsp_valid_o <= 1'b1;
            rsp_data_o  <= (cnt_q == cur_woff) ? fill_data_i : m_line[cur_woff];
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_rsp_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($past(req_valid_i && req_ready_o) || ($past(state_q) != ST_IDLE)));
  p_swap_needs_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SWAP) |-> v_hit);
  p_fill_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_valid_o && !fill_req_ready_i) |=> (fill_req_valid_o && $stable(fill_req_addr_o)));
  p_no_rsp_in_freq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_valid_o |-> !rsp_valid_o);
  p_busy_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_valid_o || state_q == ST_SWAP) |-> !req_ready_o);
endmodule

// File: tb/tb_icache_vb.sv
module tb_icache_vb;
  localparam int CLK_PERIOD = 10;
  localparam int OFFSET_W   = 4;
  localparam int INDEX_W    = 4;
  localparam int VN         = 16;
  localparam int LW         = 1 << (OFFSET_W - 2);
  localparam int LINES      = 1 << INDEX_W;
  localparam int MISS_LAT   = LW + 4;
  localparam int WD_LIMIT   = 100000;

  logic clk = 1'b0, rst_ni = 1'b0, flush_i = 1'b0;
  logic req_valid_i = 1'b0, req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic rsp_valid_o;
  logic [31:0] rsp_data_o;
  logic fill_req_valid_o, fill_req_ready_i = 1'b0;
  logic [31:0] fill_req_addr_o;
  logic fill_data_valid_i = 1'b0;
  logic [31:0] fill_data_i = '0;

  icache_vb #(.OFFSET_W(OFFSET_W), .INDEX_W(INDEX_W), .VICTIM_N(VN)) dut (
    .clk_i(clk), .rst_ni, .flush_i, .req_valid_i, .req_ready_o, .req_addr_i,
    .rsp_valid_o, .rsp_data_o, .fill_req_valid_o, .fill_req_ready_i,
    .fill_req_addr_o, .fill_data_valid_i, .fill_data_i);

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;
  int exp_kind = 0;             // 0 hit, 1 victim swap, 2 fill
  logic [31:0] exp_fill = '0;

  // reference state
  bit          mv [LINES];
  logic [31:0] mt [LINES];
  bit          vv [VN];
  logic [31:0] vk [VN];
  int          vptr = 0;

  function automatic logic [31:0] memw(input logic [31:0] a);
    return ((a >> 2) * 32'h9E37_79B1) ^ 32'h1357_2468;
  endfunction

  function automatic logic [31:0] mk(input int tag, input int idx, input int w);
    return (32'(tag) << (OFFSET_W + INDEX_W)) | (32'(idx) << OFFSET_W) | (32'(w) << 2);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic model_flush();
    for (int i = 0; i < LINES; i++) mv[i] = 1'b0;
    for (int i = 0; i < VN; i++) vv[i] = 1'b0;
    vptr = 0;
  endtask

  task automatic model_fetch(input logic [31:0] a, output int kind);
    int idx;
    logic [31:0] tag, key, okey;
    int hit_i;
    idx  = int'(a[OFFSET_W +: INDEX_W]);
    tag  = a >> (OFFSET_W + INDEX_W);
    key  = a >> OFFSET_W;
    okey = (mt[idx] << INDEX_W) | 32'(idx);
    hit_i = -1;
    if (mv[idx] && mt[idx] == tag) begin
      kind = 0;
      return;
    end
    for (int i = 0; i < VN; i++) if (vv[i] && vk[i] == key) hit_i = i;
    if (hit_i >= 0) begin
      kind = 1;
      vv[hit_i] = mv[idx];
      vk[hit_i] = okey;
    end else begin
      kind = 2;
      if (mv[idx]) begin
        vv[vptr] = 1'b1;
        vk[vptr] = okey;
        vptr = (vptr + 1) % VN;
      end
    end
    mv[idx] = 1'b1;
    mt[idx] = tag;
  endtask

  // one request; compares the outputs at every falling edge until the response
  task automatic fetch(input logic [31:0] a, input string req);
    int kind, lat;
    model_fetch(a, kind);
    exp_kind = kind;
    exp_fill = a & ~32'((1 << OFFSET_W) - 1);
    lat = (kind == 0) ? 1 : (kind == 1) ? 2 : MISS_LAT;
    chk({req, " R8 ready idle"}, 32'(req_ready_o), 32'd1);
    req_valid_i = 1'b1;
    req_addr_i  = a;
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      req_valid_i = 1'b0;
      chk($sformatf("%s rsp_valid k=%0d", req, k), 32'(rsp_valid_o), 32'(k == lat));
      if (k < lat) chk({req, " R8 ready busy"}, 32'(req_ready_o), 32'd0);
      else         chk({req, " data"}, rsp_data_o, memw(a & ~32'd3));
    end
  endtask

  // fill responder: grants one cycle late, one idle cycle after word 1
  initial begin
    forever begin
      @(negedge clk);
      if (fill_req_valid_o) begin
        chk("R1 fill address", fill_req_addr_o, exp_fill);
        chk("R4 fill expected", 32'(exp_kind), 32'd2);
        @(negedge clk);
        chk("R4 fill request held", 32'(fill_req_valid_o), 32'd1);
        fill_req_ready_i = 1'b1;
        @(negedge clk);
        fill_req_ready_i = 1'b0;
        for (int w = 0; w < LW; w++) begin
          if (w == 2) begin
            fill_data_valid_i = 1'b0;
            @(negedge clk);
          end
          fill_data_valid_i = 1'b1;
          fill_data_i = memw(fill_req_addr_o + 32'(4 * w));
          @(negedge clk);
        end
        fill_data_valid_i = 1'b0;
      end
    end
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    model_flush();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R8 reset ready", 32'(req_ready_o), 32'd1);
    chk("R2 reset rsp", 32'(rsp_valid_o), 32'd0);
    chk("R4 reset fill", 32'(fill_req_valid_o), 32'd0);

    fetch(mk(1, 1, 0), "R4 R9 cold miss");
    fetch(mk(1, 1, 3), "R2 R9 hit same line");
    fetch(mk(1, 1, 1), "R2 hit");
    fetch(mk(2, 1, 2), "R5 conflict miss evicts");
    fetch(mk(1, 1, 0), "R3 victim swap");
    fetch(mk(2, 1, 1), "R3 displaced line in victim");
    fetch(mk(2, 1, 3), "R2 R3 hit after swap");
    fetch(mk(1, 1, 2), "R3 swap back");
    fetch(mk(3, 2, 0), "R6 miss on empty line");
    fetch(mk(3, 2, 1), "R2 hit");

    // flush with a request offered in the same cycle
    flush_i = 1'b1;
    req_valid_i = 1'b1;
    req_addr_i = mk(3, 2, 1);
    #1;
    chk("R8 ready low during flush", 32'(req_ready_o), 32'd0);
    @(negedge clk);
    flush_i = 1'b0;
    req_valid_i = 1'b0;
    model_flush();
    chk("R8 request during flush ignored", 32'(rsp_valid_o), 32'd0);
    @(negedge clk);
    chk("R8 no fill from ignored request", 32'(fill_req_valid_o), 32'd0);
    fetch(mk(3, 2, 1), "R7 miss after flush");
    fetch(mk(1, 1, 0), "R7 victim cleared");

    // overrun the victim buffer on one index
    for (int t = 0; t < VN + 2; t++) fetch(mk(100 + t, 5, t % LW), "R5 fill stream");
    for (int t = 0; t < VN + 2; t++) fetch(mk(100 + t, 5, 0), "R5 round robin replay");
    fetch(mk(24'hABCDEF, 15, 3), "R1 R4 high tag miss");
    fetch(mk(24'hABCDEF, 15, 0), "R1 R2 high tag hit");
    fetch(mk(24'hABCDEE, 15, 0), "R1 tag lsb differs");
    fetch(mk(24'hABCDEF, 15, 2), "R3 high tag swap");
    @(negedge clk);
    report();
  end
endmodule